// File: doc/BRIEF.md
# Disk DMA Address and Length Engine

This block sets the memory address and the length of a byte-wide disk DMA channel. A host programs it through two byte registers. The first is an index register and the second is a data register. The index selects one byte of the 16-bit address counter, one byte of the 16-bit length counter, or the control byte. The data write then loads that byte.

Transfer requests come from the disk controller's FIFO, or from an internal loader that copies a boot ROM. The block synchronises these requests to the bus clock and raises a DMA request on the bus. For each granted cycle it presents the memory address, a map-claim strobe and a memory-valid strobe. It also forces the controller register address to zero, which selects the controller's data FIFO.

The length counter is loaded with the inverted byte count. When it reaches all ones, the block latches a done flag. Later cycles still run, but they are no longer marked valid for memory, so a partial sector can be read without any extra work in software. A control bit can stop the address counter from incrementing, so that every byte goes to one fixed address.

Top module: `dskdma_engine`

## Requirements
- R1: A write with `host_port`=0 loads the index. A write with `host_port`=1 loads the byte the index selects: index 0 is the address bits 7:0, index 1 is the address bits 15:8, index 2 is the count bits 7:0, index 3 is the count bits 15:8, and index 4 is the control byte. In the first DMA cycle that follows, `mem_addr` equals the preset address.
- R2: The address counter advances by one at the end of every DMA cycle when control bit 2 (increment enable) is 1. The 16-bit sum wraps around. When the bit is 0, the counter keeps its value.
- R3: The count is preset to the bitwise inverse of N, where N is from 1 to 65535. `mem_valid` is high in the first N DMA cycles. In every later DMA cycle `mem_valid` is low, and those cycles still take place.
- R4: `xfer_done` goes high after the length counter reaches all ones. It stays high until any byte of either counter is written, and it reads 0 from the next clock edge after such a write.
- R5: When `dma_req` and `dma_grant` are both high at a rising edge, `dma_claim` is high for exactly the next cycle. In the same edge `dma_req` drops.
- R6: `fifo_req` passes through a two-flop synchroniser. With `dma_grant` low, `dma_req` goes high at the third rising edge after `fifo_req` goes high.
- R7: `dma_claim` is never high in two cycles in a row. With the request and the grant held high in disk mode, DMA cycles occur exactly every second clock.
- R8: `ctl_addr` is 0 during a DMA cycle. In every other cycle it follows `host_dev_addr` one edge later.
- R9: `bus_irq` is the registered AND of `ctrl_irq` and control bit 1 (interrupt enable). `ctrl_reset` shows control bit 0.
- R10: When control bit 3 (ROM load) is set, requests are generated internally whatever the state of `fifo_req`, and they stop after N DMA cycles. `rom_addr` shows bits 11:0 of the address counter.
- R11: The counters hold their value in every cycle that has neither a DMA cycle nor a host write. This holds even while `dma_req` is waiting for a grant.
- R12: After reset, `dma_req`, `dma_claim`, `mem_valid`, `xfer_done`, `bus_irq` and `ctrl_reset` are 0, and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| host_we | input | 1 | Host register write strobe |
| host_port | input | 1 | 0 = index register, 1 = data register |
| host_wdata | input | 8 | Host write byte |
| host_dev_addr | input | 3 | Controller register address from the host |
| fifo_req | input | 1 | Asynchronous data request from the controller FIFO |
| dma_grant | input | 1 | Bus grant for the DMA request |
| ctrl_irq | input | 1 | Controller interrupt request |
| dma_req | output | 1 | DMA request to the bus |
| dma_claim | output | 1 | Map-claim strobe, high during each DMA cycle |
| mem_valid | output | 1 | Memory-valid strobe of the DMA cycle |
| mem_addr | output | 16 | Memory address of the DMA cycle |
| rom_addr | output | 12 | Boot ROM address (low bits of the address counter) |
| ctl_addr | output | 3 | Register address sent to the controller |
| xfer_done | output | 1 | Length counter has reached its terminal count |
| bus_irq | output | 1 | Gated interrupt to the bus |
| ctrl_reset | output | 1 | Controller reset bit |

## Verification
A host write takes effect at its own rising edge. `ctrl_reset` and `rom_addr` can be read at the next falling edge. `dma_req` follows `fifo_req` at the third edge. `dma_claim`, `mem_addr`, `mem_valid` and the zeroed `ctl_addr` all appear one edge after a sampled request and grant. The counters move at the edge that ends the DMA cycle, and `xfer_done` follows one edge after that. `bus_irq` lags `ctrl_irq` by one edge.

The bench drives every input at the falling edge and samples at the falling edge after the edge where the result is due. To check spacing, it counts falling edges between claims.

// File: rtl/dskdma_pkg.sv
package dskdma_pkg;
  localparam int BYTE_W = 8;
  localparam int CTRL_W = 4;

  typedef enum logic {
    PORT_INDEX = 1'b0,
    PORT_DATA  = 1'b1
  } host_port_e;

  // bit 0 controller reset, bit 1 irq enable, bit 2 increment, bit 3 ROM load
  typedef struct packed {
    logic rom_load;
    logic inc_en;
    logic irq_en;
    logic dev_reset;
  } dskdma_ctrl_t;
endpackage

// File: rtl/dskdma_hostregs.sv
module dskdma_hostregs import dskdma_pkg::*; #(
  parameter int IDX_W    = 3,
  parameter int IDX_CTRL = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic              host_port,
  input  logic [IDX_W-1:0]  idx_wdata,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [IDX_W-1:0]  idx_q,
  output logic              data_we,
  output dskdma_ctrl_t      ctrl_q
);
  logic idx_we;

  assign idx_we  = host_we && (host_port == PORT_INDEX);
  assign data_we = host_we && (host_port == PORT_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (idx_we) idx_q <= idx_wdata;
      if (data_we && (idx_q == IDX_W'(IDX_CTRL))) ctrl_q <= dskdma_ctrl_t'(ctrl_wdata);
    end
  end
endmodule

// File: rtl/dskdma_bytecnt.sv
module dskdma_bytecnt import dskdma_pkg::*; #(
  parameter int W     = 16,
  parameter int IDX_W = 3,
  parameter int BASE  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              step,
  output logic [W-1:0]      q,
  output logic              loaded
);
  localparam int NB = (W + BYTE_W - 1) / BYTE_W;

  logic [W-1:0]  stepped;
  logic [W-1:0]  nxt;
  logic [NB-1:0] lane_hit;

  assign stepped = q + {{(W-1){1'b0}}, step};

  // One preset strobe per byte lane; a host byte write wins over the step.
  generate
    for (genvar b = 0; b < NB; b++) begin : g_lane
      localparam int LO = b * BYTE_W;
      localparam int HI = (LO + BYTE_W > W) ? W - 1 : LO + BYTE_W - 1;
      assign lane_hit[b] = wr_en && (wr_idx == IDX_W'(BASE + b));
      assign nxt[HI:LO]  = lane_hit[b] ? wr_data[HI-LO:0] : stepped[HI:LO];
    end
  endgenerate

  assign loaded = |lane_hit;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/dskdma_reqgen.sv
module dskdma_reqgen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fifo_req,
  input  logic rom_mode,
  input  logic stop,
  input  logic dma_grant,
  output logic dma_req,
  output logic take,
  output logic cyc
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   src;

  assign src  = rom_mode ? !stop : sync_q[SYNC_STAGES-1];
  assign take = dma_req && dma_grant;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      dma_req <= 1'b0;
      cyc     <= 1'b0;
    end else begin
      sync_q[0] <= fifo_req;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      cyc <= take;
      // the granted cycle is never directly followed by another;
      // in ROM mode also wait for the counter update before asking again
      dma_req <= src && !take && !(rom_mode && cyc);
    end
  end
endmodule

// File: rtl/dskdma_engine.sv
module dskdma_engine import dskdma_pkg::*; #(
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 16,
  parameter int DEV_AW      = 3,
  parameter int ROM_AW      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic              host_port,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic [DEV_AW-1:0] host_dev_addr,
  input  logic              fifo_req,
  input  logic              dma_grant,
  input  logic              ctrl_irq,
  output logic              dma_req,
  output logic              dma_claim,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [DEV_AW-1:0] ctl_addr,
  output logic              xfer_done,
  output logic              bus_irq,
  output logic              ctrl_reset
);
  localparam int ADDR_BYTES = (ADDR_W + BYTE_W - 1) / BYTE_W;
  localparam int CNT_BYTES  = (CNT_W + BYTE_W - 1) / BYTE_W;
  localparam int IDX_ADDR   = 0;
  localparam int IDX_CNT    = IDX_ADDR + ADDR_BYTES;
  localparam int IDX_CTRL   = IDX_CNT + CNT_BYTES;

  logic [IDX_W-1:0]  idx_q;
  logic              data_we;
  dskdma_ctrl_t      ctrl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              addr_loaded;
  logic              cnt_loaded;
  logic              cnt_tc;
  logic              done_q;
  logic              stop;
  logic              take;
  logic              cyc;

  dskdma_hostregs #(.IDX_W(IDX_W), .IDX_CTRL(IDX_CTRL)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_port  (host_port),
    .idx_wdata  (host_wdata[IDX_W-1:0]),
    .ctrl_wdata (host_wdata[CTRL_W-1:0]),
    .idx_q      (idx_q),
    .data_we    (data_we),
    .ctrl_q     (ctrl_q)
  );

  dskdma_bytecnt #(.W(ADDR_W), .IDX_W(IDX_W), .BASE(IDX_ADDR)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (data_we),
    .wr_idx  (idx_q),
    .wr_data (host_wdata),
    .step    (cyc && ctrl_q.inc_en),
    .q       (addr_q),
    .loaded  (addr_loaded)
  );

  dskdma_bytecnt #(.W(CNT_W), .IDX_W(IDX_W), .BASE(IDX_CNT)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (data_we),
    .wr_idx  (idx_q),
    .wr_data (host_wdata),
    .step    (cyc),
    .q       (cnt_q),
    .loaded  (cnt_loaded)
  );

  // terminal count of the inverted-length counter, made sticky by done_q
  assign cnt_tc = &cnt_q;
  assign stop   = cnt_tc || done_q;

  dskdma_reqgen #(.SYNC_STAGES(SYNC_STAGES)) u_req (
    .clk       (clk),
    .rst       (rst),
    .fifo_req  (fifo_req),
    .rom_mode  (ctrl_q.rom_load),
    .stop      (stop),
    .dma_grant (dma_grant),
    .dma_req   (dma_req),
    .take      (take),
    .cyc       (cyc)
  );

  assign dma_claim  = cyc;
  assign xfer_done  = done_q;
  assign ctrl_reset = ctrl_q.dev_reset;
  assign rom_addr   = addr_q[ROM_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q    <= 1'b0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      ctl_addr  <= '0;
      bus_irq   <= 1'b0;
    end else begin
      if (addr_loaded || cnt_loaded) done_q <= 1'b0;
      else if (cnt_tc)               done_q <= 1'b1;
      mem_valid <= take && !stop;
      if (take) mem_addr <= addr_q;
      ctl_addr  <= take ? '0 : host_dev_addr;
      bus_irq   <= ctrl_irq && ctrl_q.irq_en;
    end
  end
endmodule

// File: rtl/dskdma_engine_chk.sv
module dskdma_engine_chk #(
  parameter int DEV_AW = 3,
  parameter int ROM_AW = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              host_we,
  input logic              dma_req,
  input logic              dma_grant,
  input logic              dma_claim,
  input logic              mem_valid,
  input logic              xfer_done,
  input logic [DEV_AW-1:0] ctl_addr,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              ctrl_irq,
  input logic              bus_irq
);
  p_valid_stop_r3: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !$past(xfer_done));
  p_valid_in_claim_r3: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> dma_claim);
  p_grant_claim_r5: assert property (@(posedge clk) disable iff (rst)
    (dma_req && dma_grant) |=> (dma_claim && !dma_req));
  p_claim_gap_r7: assert property (@(posedge clk) disable iff (rst)
    dma_claim |=> !dma_claim);
  p_fifo_sel_r8: assert property (@(posedge clk) disable iff (rst)
    dma_claim |-> (ctl_addr == '0));
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    bus_irq |-> $past(ctrl_irq));
  p_addr_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!dma_claim && !host_we) |=> $stable(rom_addr));
endmodule

bind dskdma_engine dskdma_engine_chk #(.DEV_AW(DEV_AW), .ROM_AW(ROM_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .host_we   (host_we),
  .dma_req   (dma_req),
  .dma_grant (dma_grant),
  .dma_claim (dma_claim),
  .mem_valid (mem_valid),
  .xfer_done (xfer_done),
  .ctl_addr  (ctl_addr),
  .rom_addr  (rom_addr),
  .ctrl_irq  (ctrl_irq),
  .bus_irq   (bus_irq)
);

// File: tb/dskdma_engine_tb.sv
module dskdma_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic        host_port = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [2:0]  host_dev_addr = 3'd5;
  logic        fifo_req = 1'b0;
  logic        dma_grant = 1'b0;
  logic        ctrl_irq = 1'b0;
  logic        dma_req, dma_claim, mem_valid, xfer_done, bus_irq, ctrl_reset;
  logic [15:0] mem_addr;
  logic [11:0] rom_addr;
  logic [2:0]  ctl_addr;

  int n_chk  = 0;
  int n_fail = 0;

  // {count N, start address, increment enable, extra cycles after N}
  localparam logic [40:0] VEC [4] = '{
    {16'd1, 16'h1234, 1'b1, 8'd0},
    {16'd4, 16'hFFFE, 1'b1, 8'd3},
    {16'd3, 16'h0800, 1'b0, 8'd2},
    {16'd6, 16'h00F0, 1'b1, 8'd1}
  };

  dskdma_engine u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_port(host_port),
    .host_wdata(host_wdata), .host_dev_addr(host_dev_addr), .fifo_req(fifo_req),
    .dma_grant(dma_grant), .ctrl_irq(ctrl_irq), .dma_req(dma_req),
    .dma_claim(dma_claim), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .rom_addr(rom_addr), .ctl_addr(ctl_addr), .xfer_done(xfer_done),
    .bus_irq(bus_irq), .ctrl_reset(ctrl_reset)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic port, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_port = port; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] idx, input logic [7:0] val);
    wr(1'b0, idx);
    wr(1'b1, val);
  endtask

  task automatic preset(input logic [15:0] a, input logic [15:0] n);
    logic [15:0] inv;
    inv = ~n;
    set_reg(8'd0, a[7:0]);
    set_reg(8'd1, a[15:8]);
    set_reg(8'd2, inv[7:0]);
    set_reg(8'd3, inv[15:8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk({dma_req, dma_claim, mem_valid, xfer_done, bus_irq, ctrl_reset} == 6'b0, "R12",
        {dma_req, dma_claim, mem_valid, xfer_done, bus_irq, ctrl_reset}, 0);
    chk(rom_addr == 12'h0, "R12", rom_addr, 0);
    @(negedge clk);
    chk(ctl_addr == 3'd5, "R8", ctl_addr, 5);

    // vector table, disk mode, grant held high
    for (int i = 0; i < 4; i++) begin
      logic [40:0] v;
      logic [15:0] n, a, exp_a;
      logic        inc;
      int          total, k, last;
      v = VEC[i];
      n = v[40:25]; a = v[24:9]; inc = v[8];
      total = int'(n) + int'(v[7:0]);
      set_reg(8'd4, {5'b0, inc, 2'b00});
      preset(a, n);
      chk(xfer_done == 1'b0, "R4", xfer_done, 0);
      @(negedge clk);
      fifo_req = 1'b1; dma_grant = 1'b1;
      k = 0; last = 0;
      for (int c = 0; c < 4000 && k < total; c++) begin
        @(negedge clk);
        if (dma_claim) begin
          exp_a = a + (inc ? 16'(k) : 16'd0);
          chk(mem_addr == exp_a, (k == 0) ? "R1" : "R2", mem_addr, exp_a);
          chk(mem_valid == (k < int'(n)), "R3", mem_valid, (k < int'(n)));
          chk(ctl_addr == 3'd0, "R8", ctl_addr, 0);
          if (k > 0) chk(c - last == 2, "R7", c - last, 2);
          last = c;
          k++;
          if (k == total) dma_grant = 1'b0;
        end
      end
      fifo_req = 1'b0;
      repeat (4) @(negedge clk);
      exp_a = a + (inc ? 16'(total) : 16'd0);
      chk(k == total, "R3", k, total);
      chk(xfer_done == 1'b1, "R4", xfer_done, 1);
      chk(rom_addr == exp_a[11:0], "R2", rom_addr, exp_a[11:0]);
      chk(dma_req == 1'b0, "R6", dma_req, 0);
    end

    // R4: reloading a counter byte clears done
    set_reg(8'd2, 8'h00);
    chk(xfer_done == 1'b0, "R4", xfer_done, 0);

    // R6 synchroniser latency, R11 hold while ungranted, R5 single grant
    set_reg(8'd4, 8'h04);
    preset(16'hABCD, 16'd2);
    fifo_req = 1'b1;
    @(negedge clk); chk(dma_req == 1'b0, "R6", dma_req, 0);
    @(negedge clk); chk(dma_req == 1'b0, "R6", dma_req, 0);
    @(negedge clk); chk(dma_req == 1'b1, "R6", dma_req, 1);
    begin
      bit seen;
      seen = 1'b0;
      repeat (8) begin
        @(negedge clk);
        seen |= dma_claim;
      end
      chk(seen == 1'b0, "R11", seen, 0);
      chk(rom_addr == 12'hBCD, "R11", rom_addr, 12'hBCD);
    end
    dma_grant = 1'b1;
    @(negedge clk);
    dma_grant = 1'b0;
    chk(dma_claim == 1'b1, "R5", dma_claim, 1);
    chk(mem_addr == 16'hABCD, "R5", mem_addr, 16'hABCD);
    @(negedge clk);
    chk(dma_claim == 1'b0, "R5", dma_claim, 0);
    fifo_req = 1'b0;
    repeat (4) @(negedge clk);

    // R10 ROM load mode: internal requests, stops after N
    preset(16'h2FFE, 16'd5);
    set_reg(8'd4, 8'h0C);
    dma_grant = 1'b1;
    begin
      int k;
      logic [15:0] exp_a;
      k = 0;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (dma_claim) begin
          exp_a = 16'h2FFE + 16'(k);
          chk(mem_addr == exp_a, "R10", mem_addr, exp_a);
          chk(mem_valid == 1'b1, "R10", mem_valid, 1);
          k++;
        end
      end
      chk(k == 5, "R10", k, 5);
    end
    dma_grant = 1'b0;
    chk(xfer_done == 1'b1, "R10", xfer_done, 1);
    chk(dma_req == 1'b0, "R10", dma_req, 0);
    chk(rom_addr == 12'h003, "R10", rom_addr, 12'h003);

    // R9 interrupt gating and controller reset bit
    set_reg(8'd4, 8'h00);
    ctrl_irq = 1'b1;
    repeat (2) @(negedge clk);
    chk(bus_irq == 1'b0, "R9", bus_irq, 0);
    set_reg(8'd4, 8'h02);
    @(negedge clk);
    chk(bus_irq == 1'b1, "R9", bus_irq, 1);
    ctrl_irq = 1'b0;
    @(negedge clk);
    chk(bus_irq == 1'b0, "R9", bus_irq, 0);
    set_reg(8'd4, 8'h01);
    chk(ctrl_reset == 1'b1, "R9", ctrl_reset, 1);
    host_dev_addr = 3'd3;
    @(negedge clk);
    chk(ctl_addr == 3'd3, "R8", ctl_addr, 3);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule